// File: doc/BRIEF.md
# Byte-Serial Synchronous Port Controller

This block moves one byte at a time over a four-wire synchronous serial link. It sits on a small 8-bit register bus and works either as the clock-driving end of the link or as a selected target. As the clock-driving end, a write to the data register starts an internal clock generator. The generator shifts the byte out, samples the returning byte and stops by itself after eight bit periods. As a target, it follows the serial clock of an external driver for as long as its select line is held low.

Software sets the clock idle level, the sampling phase, the bit order and one of four clock dividers through a control register. A status register holds a completion flag and a collision flag. Both flags are cleared by reading the status register and then accessing the data register. The interrupt output rises only when the completion flag is set, the local interrupt enable is set and the system-wide serial interrupt enable input is high.

Register map on `bus_addr`: 0 is control, 1 is status, 2 is data. Control bits are [7] interrupt enable, [6] block enable, [5] LSB first, [4] clock-driving mode, [3] clock idle level, [2] phase, [1:0] rate select. Status bits are [7] completion flag and [6] collision flag. The other status bits read 0.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset, control, status and data all read 0, `sck_o` is low, and `irq` and `sck_oe` are low.
- R2: When control bits 6 and 4 are set, writing address 2 sends the written byte on `mosi_o` over exactly 16 `sck_o` edges. Afterwards `sck_o` rests at the level of control bit 3.
- R3: When the byte ends, status bit 7 becomes 1 and address 2 reads back the byte received on `miso_i`.
- R4: `irq` is high only while status bit 7, control bit 7 and `ser_irq_en` are all 1.
- R5: A write to address 2 while a transfer runs sets status bit 6. The byte being shifted out is not changed.
- R6: Control bit 5 at 1 shifts LSB first in both directions. At 0, bits shift MSB first.
- R7: Rate select 0, 1, 2, 3 gives a `sck_o` half period of 2, 8, 32, 64 system cycles. These are divide ratios of 4, 16, 64 and 128.
- R8: Control bit 3 sets the idle level of the clock. With bit 2 at 0, data is sampled on the odd (leading) edges and launched on the even edges. With bit 2 at 1, data is launched on the leading edges and sampled on the trailing edges. All four combinations work.
- R9: In target mode (bit 4 at 0), with `ss_n_i` low, the block drives `miso_oe`. It sends the preloaded byte on `miso_o`, receives the `mosi_i` byte and sets status bit 7.
- R10: In target mode, with `ss_n_i` high, `miso_oe` is low and `sck_i` edges are ignored: no completion flag is set and the data register keeps its value.
- R11: The flags clear only when a status read made while a flag is set is followed by a read or write of address 2. A data access with no such status read leaves the flags set.
- R12: Address 2 returns the last completed byte. A read during a transfer returns the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on flags) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ser_irq_en | input | 1 | System-wide serial interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from external driver (target mode) |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Enable for `sck_o` |
| mosi_i | input | 1 | Serial data in (target mode) |
| mosi_o | output | 1 | Serial data out (clock-driving mode) |
| mosi_oe | output | 1 | Enable for `mosi_o` |
| miso_i | input | 1 | Serial data in (clock-driving mode) |
| miso_o | output | 1 | Serial data out (target mode) |
| miso_oe | output | 1 | Enable for `miso_o` |
| ss_n_i | input | 1 | Active-low target select |

## Verification
The collision case is the hardest to reach. The bench must place a second data write in the middle of a running byte and then prove, at the serial pins, that the first byte still went out whole. The bench's target model captures every bit of the outgoing stream and compares the byte with the expected value queued when the transfer was started. A slow rate setting leaves room for the collision write, and for a read of the data register during the transfer, before the byte ends. The deselected-target case is reached by toggling `sck_i` for a full byte with the select line high, then reading the registers back.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef struct packed {
      logic       irq_en;
      logic       en;
      logic       lsb_first;
      logic       master;
      logic       cpol;
      logic       cpha;
      logic [1:0] rate;
   } ctrl_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   // divide ratio for each rate select: base, x4, x16, x32
   function automatic int unsigned rate_div(input int unsigned base, input logic [1:0] sel);
      case (sel)
         2'd0:    return base;
         2'd1:    return base * 4;
         2'd2:    return base * 16;
         default: return base * 32;
      endcase
   endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
   import spi_port_pkg::*;
#(
   parameter int unsigned BASE_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int unsigned MAX_HALF = BASE_DIV * 16;
   localparam int unsigned CW       = $clog2(MAX_HALF + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] half_m1;

   always_comb begin
      half_m1 = CW'(rate_div(BASE_DIV, sel) / 2 - 1);
      tick    = run && (cnt == half_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt == half_m1) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_sck_sync.sv
module spi_sck_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else begin
               sr[0] <= din;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              lsb_first,
   input  logic              cpha,
   input  logic              cpol,
   input  logic              start,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              edge_ev,
   input  logic              rx_in,
   output logic              out_bit,
   output logic              running,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              sck_q
);
   localparam int unsigned EDGES = 2 * BYTE_W;
   localparam int unsigned EC_W  = $clog2(EDGES + 1);

   logic [EC_W-1:0]   ecnt, e_next;
   logic              sample_edge, is_last, launch;
   logic [BYTE_W-1:0] tx_sr, rx_sr, rx_shift, tx_shift;

   always_comb begin
      e_next      = ecnt + 1'b1;
      sample_edge = cpha ? ~e_next[0] : e_next[0];
      is_last     = (e_next == EC_W'(EDGES));
      launch      = !sample_edge && (e_next != EC_W'(1)) && !is_last;
      rx_shift    = lsb_first ? {rx_in, rx_sr[BYTE_W-1:1]} : {rx_sr[BYTE_W-2:0], rx_in};
      tx_shift    = lsb_first ? {1'b0, tx_sr[BYTE_W-1:1]} : {tx_sr[BYTE_W-2:0], 1'b0};
      out_bit     = lsb_first ? tx_sr[0] : tx_sr[BYTE_W-1];
      busy        = running || (ecnt != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt    <= '0;
         running <= 1'b0;
         done    <= 1'b0;
         tx_sr   <= '0;
         rx_sr   <= '0;
         rx_byte <= '0;
         sck_q   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) tx_sr <= load_data;
         if (abort) begin
            ecnt    <= '0;
            running <= 1'b0;
            sck_q   <= cpol;
         end else begin
            if (start) running <= 1'b1;
            if (running && edge_ev) sck_q <= ~sck_q;
            else if (!running)      sck_q <= cpol;
            if (edge_ev) begin
               ecnt <= is_last ? '0 : e_next;
               if (sample_edge) rx_sr <= rx_shift;
               if (launch)      tx_sr <= tx_shift;
               if (is_last) begin
                  running <= 1'b0;
                  done    <= 1'b1;
                  rx_byte <= sample_edge ? rx_shift : rx_sr;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic coll,
   input  logic stat_rd,
   input  logic data_acc,
   output logic spif,
   output logic wcol
);
   logic armed;
   logic clr;

   assign clr = data_acc && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         spif  <= 1'b0;
         wcol  <= 1'b0;
      end else begin
         if (clr)                         armed <= 1'b0;
         else if (stat_rd && (spif || wcol)) armed <= 1'b1;
         if (done)     spif <= 1'b1;
         else if (clr) spif <= 1'b0;
         if (coll)     wcol <= 1'b1;
         else if (clr) wcol <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
   import spi_port_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned BASE_DIV    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ser_irq_en,
   output logic              irq,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              ss_n_i
);
   localparam int unsigned STAT_PAD = BYTE_W - 2;

   if (BYTE_W != 8) begin : g_bad_width
      $error("spi_port_ctrl: control layout needs BYTE_W of 8");
   end
   if (BASE_DIV < 2 || (BASE_DIV % 2) != 0) begin : g_bad_div
      $error("spi_port_ctrl: BASE_DIV must be even and at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("spi_port_ctrl: SYNC_STAGES above 4 is not supported");
   end

   ctrl_t             ctrl;
   logic              spif, wcol, done, busy, running, tick, out_bit, sck_q;
   logic              sck_s, sck_prev, slave_edge, slave_act, edge_ev, abort;
   logic              data_wr, data_acc, stat_rd, coll, start, load;
   logic [BYTE_W-1:0] rx_byte;

   // register access decode
   always_comb begin
      data_wr  = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
      data_acc = bus_sel && (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
      stat_rd  = bus_sel && bus_rd && (bus_addr == ADDR_STAT);
      coll     = data_wr && busy;
      load     = data_wr && !busy;
      start    = load && ctrl.en && ctrl.master;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        ctrl <= '0;
      else if (bus_sel && bus_wr && bus_addr == ADDR_CTRL) ctrl <= ctrl_t'(bus_wdata);
   end

   always_comb begin
      case (bus_addr)
         ADDR_CTRL: bus_rdata = BYTE_W'(ctrl);
         ADDR_STAT: bus_rdata = {spif, wcol, {STAT_PAD{1'b0}}};
         ADDR_DATA: bus_rdata = rx_byte;
         default:   bus_rdata = '0;
      endcase
   end

   // target-side clock edge detection
   spi_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(sck_i), .dout(sck_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   always_comb begin
      slave_edge = sck_s ^ sck_prev;
      slave_act  = ctrl.en && !ctrl.master && !ss_n_i;
      abort      = !ctrl.en || (!ctrl.master && ss_n_i);
      edge_ev    = ctrl.master ? tick : (slave_edge && slave_act);
   end

   spi_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(running), .sel(ctrl.rate), .tick(tick)
   );

   spi_shift_unit #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .abort(abort), .lsb_first(ctrl.lsb_first),
      .cpha(ctrl.cpha), .cpol(ctrl.cpol), .start(start), .load(load),
      .load_data(bus_wdata), .edge_ev(edge_ev),
      .rx_in(ctrl.master ? miso_i : mosi_i), .out_bit(out_bit),
      .running(running), .busy(busy), .done(done), .rx_byte(rx_byte), .sck_q(sck_q)
   );

   spi_flag_unit u_flags (
      .clk(clk), .rst_n(rst_n), .done(done), .coll(coll), .stat_rd(stat_rd),
      .data_acc(data_acc), .spif(spif), .wcol(wcol)
   );

   always_comb begin
      irq     = spif && ctrl.irq_en && ser_irq_en;
      sck_o   = sck_q;
      sck_oe  = ctrl.en && ctrl.master;
      mosi_o  = out_bit;
      mosi_oe = ctrl.en && ctrl.master;
      miso_o  = out_bit;
      miso_oe = slave_act;
   end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sck_o,
   input logic              cpol,
   input logic              busy,
   input logic              done,
   input logic              spif,
   input logic              coll,
   input logic              wcol,
   input logic              irq,
   input logic              ser_irq_en,
   input logic              ss_n_i,
   input logic              master,
   input logic              miso_oe,
   input logic [BYTE_W-1:0] rx_byte
);
   // R2: idle generated clock rests at the programmed polarity
   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $stable(cpol)) |-> (sck_o == cpol));

   // R3: end of byte raises the completion flag
   assert_done_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> spif);

   // R5: a collision write raises the collision flag
   assert_coll_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      coll |=> wcol);

   // R4: interrupt needs the flag and the global enable
   assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (spif && ser_irq_en));

   // R10: deselected target never drives its output
   assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_n_i && !master) |-> !miso_oe);

   // R12: received value only moves at a byte boundary
   assert_rx_on_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(rx_byte) |=> spif);
endmodule

bind spi_port_ctrl spi_port_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .cpol(ctrl.cpol), .busy(busy),
   .done(done), .spif(spif), .coll(coll), .wcol(wcol), .irq(irq),
   .ser_irq_en(ser_irq_en), .ss_n_i(ss_n_i), .master(ctrl.master),
   .miso_oe(miso_oe), .rx_byte(rx_byte)
);

// File: tb/sim_spi_port_ctrl.sv
`timescale 1ns/1ps
module sim_spi_port_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
   logic [1:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic       ser_irq_en = 0;
   logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
   logic       sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   spi_port_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_irq_en(ser_irq_en), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
      .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic bitof(input logic [7:0] b, input int i, input logic lsb);
      return lsb ? b[i] : b[7-i];
   endfunction

   // ---------------- scoreboard and target model for clock-driving tests
   logic [7:0] exp_q[$];
   string      m_tag = "R2";
   logic       m_on = 0, m_cpha = 0, m_lsb = 0, m_prev = 0;
   logic [7:0] m_reply = 0, m_cap = 0;
   int         m_ecnt = 0, m_total = 0, m_lidx = 0, m_cidx = 0;

   always @(negedge clk) begin
      if (m_on && sck_o !== m_prev) begin
         bit samp;
         m_prev = sck_o;
         m_ecnt++;
         m_total++;
         samp = m_cpha ? (m_ecnt % 2 == 0) : (m_ecnt % 2 == 1);
         if (samp) begin
            m_cap[m_lsb ? m_cidx : 7 - m_cidx] = mosi_o;
            m_cidx++;
            if (m_cidx == 8) begin
               m_cidx = 0;
               if (exp_q.size() == 0) chk(0, {m_tag, " unexpected byte"}, m_cap, 0);
               else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  chk(m_cap == e, {m_tag, " mosi byte"}, m_cap, e);
               end
            end
         end else if (m_lidx < 8 && m_ecnt < 16) begin
            miso_i = bitof(m_reply, m_lidx, m_lsb);
            m_lidx++;
         end
         if (m_ecnt == 16) m_ecnt = 0;
      end
   end

   // ---------------- bus driver
   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic set_ctrl(input logic [7:0] v);
      bus_write(2'd0, v);
      m_cpha = v[2];
      m_lsb  = v[5];
      repeat (3) @(negedge clk);
   endtask

   task automatic master_xfer(input logic [7:0] tx, input logic [7:0] reply, input string tag);
      m_tag   = tag;
      m_reply = reply;
      m_lidx  = m_cpha ? 0 : 1;
      m_cidx  = 0;
      m_ecnt  = 0;
      m_total = 0;
      m_prev  = sck_o;
      miso_i  = m_cpha ? 1'b0 : bitof(reply, 0, m_lsb);
      m_on    = 1;
      exp_q.push_back(tx);
      bus_write(2'd2, tx);
   endtask

   task automatic wait_done(output logic [7:0] st);
      int n = 0;
      do begin
         bus_read(2'd1, st);
         n++;
      end while (!st[7] && n < 3000);
   endtask

   // ---------------- bench acting as clock driver for target tests
   task automatic slave_xfer(input logic [7:0] mb, input logic cpol, input logic cpha,
                             input logic lsb, input bit sel, output logic [7:0] cap);
      int li = cpha ? 0 : 1;
      int ci = 0;
      cap    = 0;
      sck_i  = cpol;
      mosi_i = cpha ? 1'b0 : bitof(mb, 0, lsb);
      repeat (8) @(negedge clk);
      ss_n_i = !sel;
      repeat (8) @(negedge clk);
      chk(miso_oe == sel, sel ? "R9 miso_oe driven" : "R10 miso_oe released", miso_oe, sel);
      for (int e = 1; e <= 16; e++) begin
         bit samp;
         samp = cpha ? (e % 2 == 0) : (e % 2 == 1);
         if (samp) begin
            cap[lsb ? ci : 7 - ci] = miso_o;
            ci++;
         end
         sck_i = ~sck_i;
         if (!samp && li < 8) begin
            mosi_i = bitof(mb, li, lsb);
            li++;
         end
         repeat (8) @(negedge clk);
      end
      ss_n_i = 1;
      repeat (8) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      finish_run();
   end

   // ---------------- main sequence
   initial begin
      logic [7:0] d, st, cap;
      int         half;
      logic       p;
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R1 reset state
      bus_read(2'd0, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
      bus_read(2'd1, d); chk(d == 8'h00, "R1 status reset", d, 0);
      bus_read(2'd2, d); chk(d == 8'h00, "R1 data reset", d, 0);
      chk(sck_o == 0 && irq == 0 && sck_oe == 0, "R1 pins reset", {sck_o, irq, sck_oe}, 0);

      // R2/R3 basic byte, mode 0, MSB first, fastest rate
      set_ctrl(8'h50);
      master_xfer(8'hA5, 8'h3C, "R2");
      wait_done(st);
      chk(st == 8'h80, "R3 done flag", st, 8'h80);
      chk(m_total == 16, "R2 edge count", m_total, 16);
      chk(sck_o == 0, "R2 clock idle low", sck_o, 0);
      bus_read(2'd2, d); chk(d == 8'h3C, "R3 received byte", d, 8'h3C);
      bus_read(2'd1, d); chk(d == 8'h00, "R11 flags cleared", d, 0);

      // R8 all four polarity/phase combinations
      for (int md = 0; md < 4; md++) begin
         logic [7:0] tx, rp;
         tx = 8'h1D + 8'(md * 8'h37);
         rp = ~tx ^ 8'h42;
         set_ctrl(8'h50 | 8'(md << 2));
         master_xfer(tx, rp, "R8");
         wait_done(st);
         chk(sck_o == md[1], "R8 clock idle level", sck_o, md[1]);
         bus_read(2'd2, d); chk(d == rp, "R8 received byte", d, rp);
      end

      // R6 LSB first, two phase settings
      for (int md = 0; md < 2; md++) begin
         set_ctrl(8'h70 | 8'(md << 2));
         master_xfer(8'hC1, 8'h0B, "R6");
         wait_done(st);
         bus_read(2'd2, d); chk(d == 8'h0B, "R6 lsb-first receive", d, 8'h0B);
      end

      // R7 rate selects
      for (int r = 0; r < 4; r++) begin
         int exp_h;
         exp_h = (r == 0) ? 2 : (r == 1) ? 8 : (r == 2) ? 32 : 64;
         set_ctrl(8'h50 | 8'(r));
         master_xfer(8'h69, 8'h96, "R7");
         p = sck_o;
         while (sck_o == p) @(negedge clk);
         p = sck_o;
         half = 0;
         do begin
            @(negedge clk);
            half++;
         end while (sck_o == p);
         chk(half == exp_h, "R7 half period", half, exp_h);
         wait_done(st);
         bus_read(2'd2, d);
      end

      // R5 collision and R12 mid-transfer read
      set_ctrl(8'h52);
      master_xfer(8'h96, 8'h5A, "R5");
      repeat (60) @(negedge clk);
      bus_read(2'd2, d); chk(d == 8'h96, "R12 previous byte mid-transfer", d, 8'h96);
      bus_write(2'd2, 8'hFF);
      wait_done(st);
      chk(st == 8'hC0, "R5 collision flag", st, 8'hC0);
      bus_read(2'd2, d); chk(d == 8'h5A, "R5 received byte intact", d, 8'h5A);
      bus_read(2'd1, d); chk(d == 8'h00, "R11 both flags cleared", d, 0);

      // R11 data access without status read leaves flags
      set_ctrl(8'h50);
      master_xfer(8'h33, 8'hE7, "R11");
      repeat (80) @(negedge clk);
      bus_read(2'd2, d);
      bus_read(2'd1, st); chk(st == 8'h80, "R11 flag kept", st, 8'h80);
      bus_read(2'd2, d);
      bus_read(2'd1, st); chk(st == 8'h00, "R11 flag cleared after sequence", st, 0);

      // R4 interrupt gating
      set_ctrl(8'hD0);
      ser_irq_en = 0;
      master_xfer(8'h4E, 8'h81, "R4");
      repeat (80) @(negedge clk);
      chk(irq == 0, "R4 irq blocked by global enable", irq, 0);
      ser_irq_en = 1;
      @(negedge clk);
      chk(irq == 1, "R4 irq raised", irq, 1);
      set_ctrl(8'h50);
      chk(irq == 0, "R4 irq blocked by local enable", irq, 0);
      bus_read(2'd1, st);
      bus_read(2'd2, d);
      set_ctrl(8'hD0);
      chk(irq == 0, "R4 irq low after clear", irq, 0);
      m_on = 0;

      // R9 target mode, two modes
      set_ctrl(8'h40);
      bus_write(2'd2, 8'hC3);
      slave_xfer(8'h6E, 1'b0, 1'b0, 1'b0, 1'b1, cap);
      chk(cap == 8'hC3, "R9 miso byte", cap, 8'hC3);
      bus_read(2'd1, st); chk(st == 8'h80, "R9 done flag", st, 8'h80);
      bus_read(2'd2, d); chk(d == 8'h6E, "R9 received byte", d, 8'h6E);
      set_ctrl(8'h6C);
      bus_write(2'd2, 8'h2B);
      slave_xfer(8'hB4, 1'b1, 1'b1, 1'b1, 1'b1, cap);
      chk(cap == 8'h2B, "R9 miso byte mode 3 lsb", cap, 8'h2B);
      bus_read(2'd1, st); chk(st == 8'h80, "R9 done flag mode 3", st, 8'h80);
      bus_read(2'd2, d); chk(d == 8'hB4, "R9 received byte mode 3", d, 8'hB4);

      // R10 deselected target ignores clock
      slave_xfer(8'h11, 1'b1, 1'b1, 1'b1, 1'b0, cap);
      bus_read(2'd1, st); chk(st == 8'h00, "R10 no flag while deselected", st, 0);
      bus_read(2'd2, d); chk(d == 8'hB4, "R10 data unchanged", d, 8'hB4);

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all queued bytes seen", exp_q.size(), 0);
      finish_run();
   end
endmodule